// File: doc/BRIEF.md
# Bidirectional GPIO Port with Software Pulldowns

This block is a byte-wide general-purpose I/O port that sits on a simple byte read/write bus of a small microcontroller. Each of its pins can be an input or an output. Three registers set it up: an output value latch, a direction mask and a pulldown-inhibit mask. Per-pin output-enable, output-value and pulldown-enable signals go to the pad. A data read returns the synchronized pin level for input pins and the latched value for output pins.

A static option input, held for as long as the block is out of reset, decides whether the software pulldowns exist at all. When the option allows them, an input pin gets its pulldown unless software has set that pin's inhibit bit. Output pins never have a pulldown. All pad controls are registered, so a pin that turns from output to input drops its driver and gains its pulldown on the same clock edge. There is no floating gap, provided software clears the inhibit bit before it clears the direction bit.

Top module: `gpio_pd_port`

## Requirements
- R1: After reset the direction mask, output latch and inhibit mask are all 0x00. One clock after reset is released, pad_oe_o and pad_do_o are 0x00, and pad_pd_o is 0xFF when pd_disable_i is 0.
- R2: A pin whose direction bit is 1 has pad_oe_o=1, drives pad_do_o from its latch bit and has pad_pd_o=0, whatever the option and inhibit settings. The pad signals follow a register write one clock later.
- R3: While pd_disable_i is 1, pad_pd_o is 0x00 on every pin, whatever the direction and inhibit values.
- R4: A pin with direction bit 0 and inhibit bit 0 has pad_pd_o=1 while pd_disable_i is 0.
- R5: A pin with inhibit bit 1 has pad_pd_o=0.
- R6: A read at offset 0x00 returns (dir & latch) | (~dir & pin), where pin is the pad level after a two-flop synchronizer. rdata_o is valid the clock after the read strobe and is 0x00 otherwise.
- R7: A write at offset 0x00 always updates the output latch, including the bits of input pins. The new value shows once the pin becomes an output.
- R8: The direction mask is written and read back at offset 0x04.
- R9: The inhibit mask is written at offset 0x10. A read at 0x10 returns 0x00.
- R10: Writes to any other offset change no register. Reads of any other offset return 0x00.
- R11: When a pin's pad_oe_o falls while pd_disable_i is 0 and its inhibit bit is 0, pad_pd_o of that pin rises in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_disable_i | input | 1 | Static option: 1 removes all pulldowns |
| addr_i | input | 5 | Bus byte offset |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, registered |
| pin_i | input | 8 | Pad level seen at each pin |
| pad_oe_o | output | 8 | Per-pin output enable |
| pad_do_o | output | 8 | Per-pin output value |
| pad_pd_o | output | 8 | Per-pin pulldown enable |

## Verification
The assertions assume that pd_disable_i does not change while reset is released. They also assume that we_i and re_i are never high together, so each bus cycle is either one write or one read. The bench changes the option only while reset is held, and its bus tasks issue a single strobe per cycle. It changes the pin levels only between bus operations and waits past the synchronizer before it reads them. Its pad model resolves an undriven pin to 0 when the pulldown is on and to 1 when the pin floats, so a data read shows the pulldown state.

// File: rtl/gpio_pd_pkg.sv
package gpio_pd_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_INH  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_pd_decode.sv
module gpio_pd_decode
  import gpio_pd_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter logic [ADDR_W-1:0] OFF_DATA = 'h00,
  parameter logic [ADDR_W-1:0] OFF_DIR  = 'h04,
  parameter logic [ADDR_W-1:0] OFF_INH  = 'h10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    if (addr_i == OFF_DATA)      sel_o = SEL_DATA;
    else if (addr_i == OFF_DIR)  sel_o = SEL_DIR;
    else if (addr_i == OFF_INH)  sel_o = SEL_INH;
    else                         sel_o = SEL_NONE;
  end
endmodule

// File: rtl/gpio_pd_regs.sv
module gpio_pd_regs
  import gpio_pd_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  reg_sel_e         sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] inh_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '0;
      dir_o   <= '0;
      inh_o   <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_DATA: latch_o <= wdata_i;
        SEL_DIR:  dir_o   <= wdata_i;
        SEL_INH:  inh_o   <= wdata_i;
        default: ;
      endcase
    end
  end

  // R8
  dir_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_DIR) |=> dir_o == $past(wdata_i));

  // R7
  latch_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_DATA) |=> latch_o == $past(wdata_i));

  // R10
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_NONE) |=> ($stable(latch_o) && $stable(dir_o) && $stable(inh_o)));
endmodule

// File: rtl/gpio_pd_sync.sv
module gpio_pd_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/gpio_pd_padctl.sv
module gpio_pd_padctl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_disable_i,
  input  logic [WIDTH-1:0] latch_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] inh_i,
  output logic [WIDTH-1:0] oe_o,
  output logic [WIDTH-1:0] do_o,
  output logic [WIDTH-1:0] pd_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        oe_o[g] <= 1'b0;
        do_o[g] <= 1'b0;
        pd_o[g] <= 1'b0;
      end else begin
        oe_o[g] <= dir_i[g];
        do_o[g] <= latch_i[g];
        pd_o[g] <= !pd_disable_i && !dir_i[g] && !inh_i[g];
      end
    end

    // R2
    oe_no_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_o[g] |-> !pd_o[g]);

    // R11
    pd_handoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(oe_o[g]) && !pd_disable_i && !$past(inh_i[g])) |-> pd_o[g]);

    // R5
    inh_blocks_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inh_i[g] |=> !pd_o[g]);
  end

  // R3
  opt_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_disable_i |=> pd_o == '0);

  opt_static_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(pd_disable_i));
endmodule

// File: rtl/gpio_pd_port.sv
module gpio_pd_port
  import gpio_pd_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] OFF_DATA = 'h00,
  parameter logic [ADDR_W-1:0] OFF_DIR  = 'h04,
  parameter logic [ADDR_W-1:0] OFF_INH  = 'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_disable_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pad_oe_o,
  output logic [WIDTH-1:0]  pad_do_o,
  output logic [WIDTH-1:0]  pad_pd_o
);
  reg_sel_e         sel;
  logic [WIDTH-1:0] latch_q, dir_q, inh_q, pin_s, rd_mux;

  gpio_pd_decode #(
    .ADDR_W(ADDR_W), .OFF_DATA(OFF_DATA), .OFF_DIR(OFF_DIR), .OFF_INH(OFF_INH)
  ) u_dec (
    .addr_i(addr_i), .sel_o(sel)
  );

  gpio_pd_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .sel_i(sel), .wdata_i(wdata_i),
    .latch_o(latch_q), .dir_o(dir_q), .inh_o(inh_q)
  );

  gpio_pd_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_s)
  );

  gpio_pd_padctl #(.WIDTH(WIDTH)) u_pad (
    .clk_i(clk_i), .rst_ni(rst_ni), .pd_disable_i(pd_disable_i),
    .latch_i(latch_q), .dir_i(dir_q), .inh_i(inh_q),
    .oe_o(pad_oe_o), .do_o(pad_do_o), .pd_o(pad_pd_o)
  );

  // inhibit mask is write-only; its offset reads as zero
  always_comb begin
    unique case (sel)
      SEL_DATA: rd_mux = (dir_q & latch_q) | (~dir_q & pin_s);
      SEL_DIR:  rd_mux = dir_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_mux;
    else           rdata_o <= '0;
  end

  // R9
  inh_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && sel == SEL_INH) |=> rdata_o == '0);

  // R10
  unmapped_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && sel == SEL_NONE) |=> rdata_o == '0);

  // R6
  idle_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> rdata_o == '0);

  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && re_i));
endmodule

// File: tb/sim_gpio_pd_port.sv
module sim_gpio_pd_port;
  localparam int W = 8;
  localparam logic [4:0] A_DATA = 5'h00, A_DIR = 5'h04, A_INH = 5'h10, A_BAD = 5'h08;

  logic clk = 1'b0, rst_n = 1'b0, pd_dis = 1'b0;
  logic [4:0] addr = '0;
  logic [W-1:0] wdata = '0, rdata, pin, oe, dout, pd;
  logic we = 1'b0, re = 1'b0;
  logic [W-1:0] ext_en = '0, ext_val = '0;

  int checks = 0, errors = 0, cyc = 0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];
  logic pend = 1'b0;

  always #2 clk = ~clk;

  // pad model: driven value, else external source, else pulldown 0, else float seen as 1
  for (genvar i = 0; i < W; i++) begin : g_pad
    assign pin[i] = oe[i] ? dout[i] : ext_en[i] ? ext_val[i] : pd[i] ? 1'b0 : 1'b1;
  end

  gpio_pd_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .pd_disable_i(pd_dis), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .pin_i(pin),
    .pad_oe_o(oe), .pad_do_o(dout), .pad_pd_o(pd)
  );

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h exp %02h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [W-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  // driver: push expected item, issue read
  task automatic rd(input logic [4:0] a, input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
  endtask

  // monitor
  always @(posedge clk) pend <= re;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard empty got %02h exp none", rdata);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic do_reset(input logic opt);
    @(negedge clk);
    rst_n = 1'b0; pd_dis = opt;
    idle(2);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog got %0d exp below 20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    idle(3);
    chk("R1 pad_oe", oe, 8'h00);
    chk("R1 pad_do", dout, 8'h00);
    chk("R1 pad_pd", pd, 8'hFF);
    rd(A_DIR, 8'h00, "R1 dir reset");
    rd(A_DATA, 8'h00, "R1/R6 data all inputs pulled low");

    wr(A_DIR, 8'h5A);
    rd(A_DIR, 8'h5A, "R8 dir readback");
    wr(A_DATA, 8'hF0);
    idle(3);
    chk("R2 pad_oe", oe, 8'h5A);
    chk("R2 pad_do", dout, 8'hF0);
    chk("R4 pad_pd", pd, 8'hA5);
    rd(A_DATA, 8'h50, "R6 mixed latch/pin");

    ext_en = 8'hFF; ext_val = 8'h3C;
    idle(3);
    rd(A_DATA, 8'h74, "R6 driven input pins");
    ext_en = 8'h00;

    wr(A_INH, 8'h0F);
    idle(3);
    chk("R5 pad_pd inhibit", pd, 8'hA0);
    rd(A_DATA, 8'h55, "R5 inhibited inputs float");
    rd(A_INH, 8'h00, "R9 inhibit reads zero");

    wr(A_BAD, 8'hFF);
    rd(A_DIR, 8'h5A, "R10 dir unchanged");
    rd(A_DATA, 8'h55, "R10 data unchanged");
    rd(A_BAD, 8'h00, "R10 unmapped read");
    idle(1);
    chk("R10 pad_pd unchanged", pd, 8'hA0);

    // R11: bit 6 output -> input with inhibit clear
    wr(A_DIR, 8'h18);
    chk("R11 before edge oe", oe & 8'h42, 8'h42);
    chk("R11 before edge pd", pd & 8'h40, 8'h00);
    idle(1);
    chk("R11 oe", oe, 8'h18);
    chk("R11 pd same cycle", pd, 8'hE0);

    wr(A_DATA, 8'h0F);
    wr(A_DIR, 8'hFF);
    idle(2);
    chk("R7 latch via input write", dout, 8'h0F);
    chk("R2 all out no pd", pd, 8'h00);
    rd(A_DATA, 8'h0F, "R7 data readback");

    do_reset(1'b1);
    idle(3);
    chk("R3 pd off after reset", pd, 8'h00);
    wr(A_INH, 8'h00);
    wr(A_DIR, 8'h00);
    idle(3);
    chk("R3 pd off all inputs", pd, 8'h00);
    rd(A_DATA, 8'hFF, "R3 inputs float");

    idle(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule